// File: doc/BRIEF.md
# Dual-bridge phase-shifted PWM generator

This block produces the gate patterns for two identical bridge converter modules from one free-running timebase. A fixed half-period complementary pair drives the AC-side bridge and is shared by every module. Each module also drives a DC-side full bridge from two compare-based PWM channels. Both channels get a programmable dead band. The second channel runs on its own counter, which is reloaded with a saturated phase value at every period start. Because of this reload, its pattern is shifted against the first channel by that many clock cycles.

A control loop computes new compare, phase and dead-band values every switching period and writes them through a single write port. Each write goes into a shadow copy. The copy is moved into the active set only when the timebase reaches its terminal count, so a period never mixes old and new settings. A set of overcurrent comparator inputs feeds a sticky trip flag. The flag drops every output and the driver enable at once, and only the asynchronous reset clears it. After reset, every output stays low until the first period start.

Top module: `dual_bridge_pwm`

## Requirements
- R1: The shared count runs 0 to PERIOD-1 and then wraps. While running, `ac_o[0]` is high for count < PERIOD/2 and `ac_o[1]` is high for the rest of the period. Each is high for PERIOD/2 cycles per period, and the two are never high together.
- R2: A DC channel is active while its own count is >= A and < B. The high-side output `dc_o[4m+2c]` (module m, channel c) is high for (B-A)-DB cycles per period. The low-side output `dc_o[4m+2c+1]` is high for PERIOD-(B-A)-DB cycles per period, where DB is the module's dead band.
- R3: The two outputs of a DC channel are never high in the same cycle. After either one falls, its partner rises exactly DB cycles later; with DB=0 this happens in the same cycle.
- R4: Channel 0 of every module uses the shared count. At each period start, channel 1 loads its counter with the module's phase value. As a result, the rising edge of the channel 0 high-side output comes phase cycles (mod PERIOD) after that of channel 1.
- R5: A written phase greater than MAX_PHASE takes effect as MAX_PHASE.
- R6: A write uses the address {module, field}, with the field in the low 3 bits. The field codes are: 0 = channel 0 A, 1 = channel 0 B, 2 = channel 1 A, 3 = channel 1 B, 4 = phase, 5 = dead band (low DB_W bits of the data). A write changes only the shadow copy. The copy becomes active at the terminal count, so the period that is running keeps its old settings.
- R7: A high on any bit of `oc_i` sets the trip flag at the next clock edge. Bit 2m is the input-current trip of module m and bit 2m+1 is its output-current trip. From that edge on, `fault_o` is 1, `drv_en_o` is 0, and all of `ac_o` and `dc_o` are 0.
- R8: The trip flag stays set after `oc_i` returns low. Only `rst_ni` clears it.
- R9: After reset is released, all outputs stay low until the first period start, which is PERIOD clock edges later. Normal output begins there, unless a trip arrives in that same boundary cycle; in that case all outputs stay low.
- R10: During reset, `ac_o` and `dc_o` are 0, `fault_o` is 0 and `drv_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low; the only way to clear a trip |
| wr_en_i | input | 1 | Write strobe for the shadow settings |
| wr_addr_i | input | MOD_W+3 | {module index, field code} |
| wr_data_i | input | CW | Compare, phase or dead-band value |
| oc_i | input | 2*NUM_MOD | Overcurrent trips, two per module |
| ac_o | output | 2 | AC-side complementary pair: [0] first half, [1] second half |
| dc_o | output | 4*NUM_MOD | DC-side outputs: per module, channel 0 high/low, then channel 1 high/low |
| fault_o | output | 1 | Sticky trip flag |
| drv_en_o | output | 1 | Gate driver enable, low while tripped |

## Verification
Two events can fall in the same cycle. In the boundary cycle that first releases the outputs after reset, a trip can also arrive. The bench counts PERIOD-1 edges after releasing reset and raises a trip input exactly in the terminal-count cycle. It then requires every output to stay low, with the flag set, from the following edge on. A second overlap is a shadow write inside a period that is being measured. Each sweep step writes the next settings while it counts pulse widths and edge offsets of the running period, and those counts must match the old settings.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
  localparam int unsigned FLD_W = 3;
  typedef enum logic [FLD_W-1:0] {
    FLD_A0 = 3'd0,
    FLD_B0 = 3'd1,
    FLD_A1 = 3'd2,
    FLD_B1 = 3'd3,
    FLD_PH = 3'd4,
    FLD_DB = 3'd5
  } fld_e;
endpackage

// File: rtl/dbpwm_counter.sv
module dbpwm_counter #(
  parameter int unsigned PERIOD = 6000,
  parameter int unsigned CW     = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (load_i)        cnt_o <= load_val_i;
    else if (cnt_o == LAST) cnt_o <= '0;
    else                    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dbpwm_deadband.sv
module dbpwm_deadband #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic [DB_W-1:0] db_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            raw_q;
  logic [DB_W-1:0] tmr_q;

  // every edge of the raw pattern restarts the blanking timer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      tmr_q <= '0;
    end else begin
      raw_q <= raw_i;
      if (raw_i != raw_q)  tmr_q <= db_i;
      else if (tmr_q != 0) tmr_q <= tmr_q - 1'b1;
    end
  end

  assign hi_o = raw_q  && (tmr_q == '0);
  assign lo_o = !raw_q && (tmr_q == '0);
endmodule

// File: rtl/dbpwm_regs.sv
module dbpwm_regs import dbpwm_pkg::*; #(
  parameter int unsigned CW        = 13,
  parameter int unsigned DB_W      = 8,
  parameter int unsigned MAX_PHASE = 2400,
  parameter int unsigned MOD_W     = 1,
  parameter int unsigned IDX       = 0,
  localparam int unsigned ADDR_W   = MOD_W + FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CW-1:0]     wr_data_i,
  input  logic              sync_i,
  output logic [CW-1:0]     a0_o,
  output logic [CW-1:0]     b0_o,
  output logic [CW-1:0]     a1_o,
  output logic [CW-1:0]     b1_o,
  output logic [DB_W-1:0]   db_o,
  output logic [CW-1:0]     ph_ld_o
);
  localparam logic [CW-1:0] PH_MAX = CW'(MAX_PHASE);

  logic [CW-1:0]   sh_a0, sh_b0, sh_a1, sh_b1, sh_ph;
  logic [DB_W-1:0] sh_db;
  logic            hit;

  assign hit = wr_en_i && (wr_addr_i[ADDR_W-1:FLD_W] == MOD_W'(IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_a0 <= '0; sh_b0 <= '0; sh_a1 <= '0; sh_b1 <= '0; sh_ph <= '0; sh_db <= '0;
    end else if (hit) begin
      case (fld_e'(wr_addr_i[FLD_W-1:0]))
        FLD_A0:  sh_a0 <= wr_data_i;
        FLD_B0:  sh_b0 <= wr_data_i;
        FLD_A1:  sh_a1 <= wr_data_i;
        FLD_B1:  sh_b1 <= wr_data_i;
        FLD_PH:  sh_ph <= wr_data_i;
        FLD_DB:  sh_db <= wr_data_i[DB_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a0_o <= '0; b0_o <= '0; a1_o <= '0; b1_o <= '0; db_o <= '0;
    end else if (sync_i) begin
      a0_o <= sh_a0; b0_o <= sh_b0; a1_o <= sh_a1; b1_o <= sh_b1; db_o <= sh_db;
    end
  end

  // saturated phase, consumed by the channel 1 counter at the boundary
  assign ph_ld_o = (sh_ph > PH_MAX) ? PH_MAX : sh_ph;
endmodule

// File: rtl/dual_bridge_pwm.sv
module dual_bridge_pwm import dbpwm_pkg::*; #(
  parameter int unsigned PERIOD    = 6000,
  parameter int unsigned MAX_PHASE = 2400,
  parameter int unsigned NUM_MOD   = 2,
  parameter int unsigned DB_W      = 8,
  localparam int unsigned CW       = $clog2(PERIOD),
  localparam int unsigned MOD_W    = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1,
  localparam int unsigned ADDR_W   = MOD_W + FLD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CW-1:0]        wr_data_i,
  input  logic [2*NUM_MOD-1:0] oc_i,
  output logic [1:0]           ac_o,
  output logic [4*NUM_MOD-1:0] dc_o,
  output logic                 fault_o,
  output logic                 drv_en_o
);
  localparam int unsigned   CFG_W = 4*CW + DB_W;
  localparam logic [CW-1:0] HALF  = CW'(PERIOD/2);
  localparam logic [CW-1:0] LAST  = CW'(PERIOD-1);

  logic [CW-1:0]                   cnt0;
  logic                            sync, run_q, fault_q, ena;
  logic [NUM_MOD-1:0][CW-1:0]      cnt1;
  logic [NUM_MOD-1:0][CFG_W-1:0]   cfg_all;

  dbpwm_counter #(.PERIOD(PERIOD), .CW(CW)) u_tbase (
    .clk_i, .rst_ni, .load_i(1'b0), .load_val_i('0), .cnt_o(cnt0)
  );

  assign sync = (cnt0 == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      fault_q <= fault_q | (|oc_i);
      run_q   <= run_q | sync;
    end
  end

  assign ena      = run_q && !fault_q;
  assign fault_o  = fault_q;
  assign drv_en_o = !fault_q;
  assign ac_o     = {ena && (cnt0 >= HALF), ena && (cnt0 < HALF)};

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic [1:0][CW-1:0] ca, cb, cc;
    logic [DB_W-1:0]    db;
    logic [CW-1:0]      ph_ld;
    logic [1:0]         hi, lo;

    dbpwm_regs #(
      .CW(CW), .DB_W(DB_W), .MAX_PHASE(MAX_PHASE), .MOD_W(MOD_W), .IDX(m)
    ) u_regs (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .sync_i(sync),
      .a0_o(ca[0]), .b0_o(cb[0]), .a1_o(ca[1]), .b1_o(cb[1]),
      .db_o(db), .ph_ld_o(ph_ld)
    );

    dbpwm_counter #(.PERIOD(PERIOD), .CW(CW)) u_phcnt (
      .clk_i, .rst_ni, .load_i(sync), .load_val_i(ph_ld), .cnt_o(cnt1[m])
    );

    assign cc[0]      = cnt0;
    assign cc[1]      = cnt1[m];
    assign cfg_all[m] = {ca[0], cb[0], ca[1], cb[1], db};

    for (genvar c = 0; c < 2; c++) begin : g_ch
      dbpwm_deadband #(.DB_W(DB_W)) u_db (
        .clk_i, .rst_ni,
        .raw_i((cc[c] >= ca[c]) && (cc[c] < cb[c])),
        .db_i(db), .hi_o(hi[c]), .lo_o(lo[c])
      );
      assign dc_o[4*m+2*c]   = ena && hi[c];
      assign dc_o[4*m+2*c+1] = ena && lo[c];
    end
  end
endmodule

// File: rtl/dual_bridge_pwm_chk.sv
module dual_bridge_pwm_chk #(
  parameter int unsigned PERIOD    = 6000,
  parameter int unsigned MAX_PHASE = 2400,
  parameter int unsigned NUM_MOD   = 2,
  parameter int unsigned CW        = 13,
  parameter int unsigned CFG_W     = 60
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [2*NUM_MOD-1:0]          oc_i,
  input logic [1:0]                    ac_o,
  input logic [4*NUM_MOD-1:0]          dc_o,
  input logic                          fault_o,
  input logic                          drv_en_o,
  input logic                          sync_i,
  input logic [NUM_MOD-1:0][CW-1:0]    cnt1_i,
  input logic [NUM_MOD-1:0][CFG_W-1:0] cfg_i
);
  a_r1_ac_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ac_o[0] && ac_o[1]));

  for (genvar i = 0; i < 2*NUM_MOD; i++) begin : g_pair
    a_r3_pair_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dc_o[2*i] && dc_o[2*i+1]));
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_ph
    a_r5_phase_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_i |=> (cnt1_i[m] <= CW'(MAX_PHASE)));
    a_r4_ch1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_i && cnt1_i[m] != CW'(PERIOD-1)) |=> (cnt1_i[m] == $past(cnt1_i[m]) + 1'b1));
  end

  a_r6_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(cfg_i));

  a_r7_trip_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|oc_i) |=> (fault_o && !drv_en_o));

  a_r7_outputs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (dc_o == '0 && ac_o == '0));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
endmodule

bind dual_bridge_pwm dual_bridge_pwm_chk #(
  .PERIOD(PERIOD), .MAX_PHASE(MAX_PHASE), .NUM_MOD(NUM_MOD), .CW(CW), .CFG_W(CFG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oc_i(oc_i), .ac_o(ac_o), .dc_o(dc_o),
  .fault_o(fault_o), .drv_en_o(drv_en_o), .sync_i(sync), .cnt1_i(cnt1), .cfg_i(cfg_all)
);

// File: tb/tb_dual_bridge_pwm.sv
module tb_dual_bridge_pwm;
  localparam int P    = 40;
  localparam int MAXP = 15;
  localparam int NM   = 2;
  localparam int DBW  = 4;
  localparam int CW   = $clog2(P);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [3:0]    oc = '0;
  logic [1:0]    ac;
  logic [7:0]    dc;
  logic          fault, drv_en;

  dual_bridge_pwm #(.PERIOD(P), .MAX_PHASE(MAXP), .NUM_MOD(NM), .DB_W(DBW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .oc_i(oc), .ac_o(ac), .dc_o(dc),
    .fault_o(fault), .drv_en_o(drv_en)
  );

  always #4 clk = ~clk;

  int   n_chk = 0, n_fail = 0;
  logic ac_prev = 1'b0;
  logic [7:0] dc_prev = '0;
  int   phl [4] = '{0, 7, 15, 30};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic tick();
    ac_prev = ac[0];
    dc_prev = dc;
    @(posedge clk);
    #2;
  endtask

  task automatic wait_start();
    int g = 0;
    do begin
      tick();
      g++;
    end while (!(ac[0] && !ac_prev) && g < 3*P);
  endtask

  function automatic int cfg_a(input int m, input int k);
    return (m == 0) ? 8 : 2 + (k % 5);
  endfunction
  function automatic int cfg_b(input int m, input int k);
    return (m == 0) ? 20 + 4*(k % 3) : 33;
  endfunction
  function automatic int cfg_ph(input int m, input int k);
    return (m == 0) ? phl[k % 4] : phl[(k + 1) % 4];
  endfunction

  task automatic wr_cfg(input int k);
    for (int m = 0; m < NM; m++) begin
      int vals [6];
      vals = '{cfg_a(m,k), cfg_b(m,k), cfg_a(m,k), cfg_b(m,k), cfg_ph(m,k), k / 4};
      for (int f = 0; f < 6; f++) begin
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = {m[0], f[2:0]};
        wr_data = CW'(vals[f]);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // window starts at current sample (shared count 0)
  task automatic measure(input int k);
    int hc [8];
    int rise [8];
    int ac0 = 0, ac1 = 0, excl = 0;
    for (int j = 0; j < 8; j++) begin hc[j] = 0; rise[j] = -1; end
    for (int i = 0; i < P; i++) begin
      if (i > 0) tick();
      if (ac[0]) ac0++;
      if (ac[1]) ac1++;
      if (ac[0] == ac[1]) excl++;
      for (int j = 0; j < 8; j++) begin
        if (dc[j]) hc[j]++;
        if (dc[j] && !dc_prev[j]) rise[j] = i;
      end
      for (int j = 0; j < 4; j++) if (dc[2*j] && dc[2*j+1]) excl++;
    end
    chk(ac0 == P/2, "R1 ac high", ac0, P/2);
    chk(ac1 == P/2, "R1 ac low", ac1, P/2);
    chk(excl == 0, "R3 R1 overlap", excl, 0);
    for (int m = 0; m < NM; m++) begin
      int w  = cfg_b(m,k) - cfg_a(m,k);
      int db = k / 4;
      int ph = (cfg_ph(m,k) > MAXP) ? MAXP : cfg_ph(m,k);
      int d;
      for (int c = 0; c < 2; c++) begin
        chk(hc[4*m+2*c] == w - db, "R2,R3,R6 high width", hc[4*m+2*c], w - db);
        chk(hc[4*m+2*c+1] == P - w - db, "R2,R3,R6 low width", hc[4*m+2*c+1], P - w - db);
      end
      d = (rise[4*m] - rise[4*m+2]) % P;
      if (d < 0) d += P;
      if (cfg_ph(m,k) > MAXP) chk(d == ph, "R5 clamped phase", d, ph);
      else                    chk(d == ph, "R4 phase", d, ph);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) tick();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int bad;
    repeat (3) tick();
    chk(ac == 0 && dc == 0, "R10 outputs in reset", {ac, dc}, 0);
    chk(fault == 0 && drv_en == 1, "R10 flag in reset", {fault, drv_en}, 1);
    @(negedge clk);
    rst_ni = 1'b1;

    // R9: idle until the first boundary
    bad = 0;
    for (int i = 0; i < P-1; i++) begin
      tick();
      if (ac != 0 || dc != 0) bad++;
    end
    chk(bad == 0, "R9 idle before first start", bad, 0);
    tick();
    chk(ac == 2'b01, "R9 ac at first start", ac, 1);
    chk(dc == 8'haa, "R2 R9 zero config low sides", dc, 8'haa);

    // sweep: dead band 0..3 x phase list; next settings written during measured period
    wr_cfg(0);
    wait_start();
    wait_start();
    for (int k = 0; k < 16; k++) begin
      fork
        begin if (k < 15) wr_cfg(k + 1); end
        measure(k);
      join
      wait_start();
      wait_start();
    end

    // R7/R8: each trip bit
    for (int b = 0; b < 4; b++) begin
      do_reset();
      wait_start();
      repeat (5) tick();
      @(negedge clk);
      oc[b] = 1'b1;
      tick();
      chk(fault == 1 && drv_en == 0, "R7 trip flag", {fault, drv_en}, 2);
      chk(ac == 0 && dc == 0, "R7 outputs low", {ac, dc}, 0);
      @(negedge clk);
      oc = '0;
      bad = 0;
      for (int i = 0; i < 2*P; i++) begin
        tick();
        if (!fault || drv_en || ac != 0 || dc != 0) bad++;
      end
      chk(bad == 0, "R8 sticky trip", bad, 0);
      @(negedge clk);
      rst_ni = 1'b0;
      tick();
      chk(fault == 0 && drv_en == 1, "R8 cleared by reset", {fault, drv_en}, 1);
    end

    // R9: trip in the first boundary cycle
    do_reset();
    repeat (P-1) tick();
    @(negedge clk);
    oc[1] = 1'b1;
    tick();
    chk(fault == 1, "R9 trip at boundary flag", fault, 1);
    chk(ac == 0 && dc == 0, "R9 trip at boundary outputs", {ac, dc}, 0);
    @(negedge clk);
    oc = '0;
    bad = 0;
    for (int i = 0; i < 2*P; i++) begin
      tick();
      if (ac != 0 || dc != 0) bad++;
    end
    chk(bad == 0, "R9 stays low after boundary trip", bad, 0);
    summary();
  end
endmodule